// File: doc/BRIEF.md
# Parallel Multi-Table Lookup Unit

This functional unit sits beside the ALU of a processor pipeline and holds eight small on-chip tables of 256 entries each. Every table has a single read port and a single write port. A lookup operation takes consecutive bytes of a source word and uses them as indices, one table per byte. It reads up to eight tables in the same cycle, trims each entry to a selected width and packs the pieces side by side into one result word. A write operation stores one entry of one table.

Both operations arrive on a one-cycle issue interface. That interface carries an operation bit, three sub-op fields and two source words. The outcome appears one clock after issue. A small result state machine records what the output presents. Its states are `S_IDLE` (nothing issued), `S_LOOKUP` (packed lookup data), `S_WRITE` (write accepted, result zero) and `S_FAULT` (illegal field combination, error raised, result zero). Every clock edge moves it to one of these states. With no issue it goes to `S_IDLE`. An illegal issue goes to `S_FAULT`. A legal write goes to `S_WRITE` and a legal lookup goes to `S_LOOKUP`. Default sizing is a 64-bit word and 32-bit table entries.

Top module: `tbl_lookup_unit`

## Requirements
- R1: Lookup number j always reads table Tj. Its index is byte (off + j) of `src_a`, where byte 0 is `src_a[7:0]` and off is `issue_off`.
- R2: For a lookup, `issue_fa` holds the lookup count minus one, so codes 0 to 7 select 1 to 8 parallel lookups.
- R3: Size codes 0, 1, 2, 3 and 4 on `issue_size` select 1, 2, 4, 8 and 16 bytes. Only the least significant bytes of each entry are returned. Bytes beyond the 4-byte entry read as zero.
- R4: With D bytes per lookup, the result of lookup j sits in `result[j*8*D +: 8*D]`, and every result bit above the last lookup is zero.
- R5: A write (`issue_op`=1) updates only table `issue_fa`. The entry index is byte `issue_off` of `src_a`. The entry receives the low size-code bytes of `src_b` with the rest of the entry zero-filled.
- R6: Size codes 5 to 7 are reserved. They raise `err`, return a zero result and leave every table unchanged.
- R7: A lookup whose count times size exceeds 8 bytes raises `err` with a zero result.
- R8: A lookup whose last index byte (off + count − 1) exceeds byte 7 raises `err`. So does a write whose offset exceeds 7. Neither changes any table.
- R9: A write whose data size exceeds the 4-byte entry raises `err` and changes no table.
- R10: `done`, `err` and `result` reflect an issue exactly one clock after it. In the cycle after a clock with no issue, and after reset, all three are zero.
- R11: A legal write returns `done`=1, `err`=0 and a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 1 | 0 = parallel lookup, 1 = table write |
| issue_fa | input | 3 | Lookup count minus one, or target table for a write |
| issue_size | input | 3 | Data size code, bytes = 2^code |
| issue_off | input | 4 | Byte of `src_a` used as the first index |
| src_a | input | 64 | Index source word |
| src_b | input | 64 | Write data source word |
| done | output | 1 | Result of last cycle's issue is present |
| err | output | 1 | Last cycle's issue was illegal |
| result | output | 64 | Packed lookup data, zero otherwise |

## Verification
Every outcome of this unit is due one clock after its issue cycle: packed data, the error flag and the `done` pulse. A table write is visible to a lookup issued in any later cycle. The bench drives each operation on a falling edge and holds it across exactly one rising edge. It reads `done`, `err` and `result` on the next falling edge, then checks the following idle cycle for all-zero outputs. Writes that must have no effect are confirmed by a later lookup that reads the affected entry back through the result port.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_LOOKUP = 2'd1,
        S_WRITE  = 2'd2,
        S_FAULT  = 2'd3
    } res_state_e;

    localparam logic OP_LOOKUP = 1'b0;
    localparam logic OP_WRITE  = 1'b1;

    // highest size code with a defined width (16 bytes)
    localparam logic [2:0] SIZE_CODE_MAX = 3'd4;

endpackage

// File: rtl/tlu_decode.sv
module tlu_decode
    import tlu_pkg::*;
#(
    parameter int WORD_BYTES  = 8,
    parameter int ENTRY_BYTES = 4,
    parameter int NUM_TABLES  = 8
) (
    input  logic                         valid,
    input  logic                         op,
    input  logic [2:0]                   fa,
    input  logic [2:0]                   sz,
    input  logic [3:0]                   off,
    input  logic [WORD_BYTES*8-1:0]      src_a,
    input  logic [ENTRY_BYTES*8-1:0]     src_b_lo,
    output logic                         legal,
    output logic [7:0]                   cnt,
    output logic [NUM_TABLES-1:0]        rd_en,
    output logic [NUM_TABLES-1:0][7:0]   rd_idx,
    output logic [NUM_TABLES-1:0]        wr_en,
    output logic [7:0]                   wr_idx,
    output logic [ENTRY_BYTES*8-1:0]     wr_data
);

    localparam int         WW  = WORD_BYTES * 8;
    localparam logic [7:0] WB8 = 8'(WORD_BYTES);
    localparam logic [7:0] EB8 = 8'(ENTRY_BYTES);
    localparam logic [7:0] NT8 = 8'(NUM_TABLES);

    logic [7:0] off8, sbytes, span, last_pos;
    logic       rsvd, lk_ok, wr_ok;
    logic [WW-1:0] wr_sh;

    always_comb begin
        off8     = {4'b0, off};
        cnt      = {5'b0, fa} + 8'd1;
        sbytes   = 8'd1 << sz;
        span     = cnt << sz;
        last_pos = off8 + cnt - 8'd1;
        rsvd     = sz > SIZE_CODE_MAX;
        lk_ok    = !rsvd && (span <= WB8) && (last_pos < WB8) && (cnt <= NT8);
        wr_ok    = !rsvd && (sbytes <= EB8) && (off8 < WB8) && ({5'b0, fa} < NT8);
        legal    = (op == OP_WRITE) ? wr_ok : lk_ok;
    end

    // one index byte per table, walking leftwards from the offset byte
    for (genvar j = 0; j < NUM_TABLES; j++) begin : g_idx
        logic [7:0]    pos;
        logic [WW-1:0] sh;
        assign pos       = off8 + 8'(j);
        assign sh        = src_a >> {pos, 3'b000};
        assign rd_idx[j] = sh[7:0];
        assign rd_en[j]  = valid && legal && (op == OP_LOOKUP) && (8'(j) < cnt);
    end

    assign wr_sh  = src_a >> {off8, 3'b000};
    assign wr_idx = wr_sh[7:0];
    assign wr_en  = (valid && legal && (op == OP_WRITE))
                    ? (NUM_TABLES'(1) << fa) : '0;

    always_comb begin
        wr_data = '0;
        for (int k = 0; k < ENTRY_BYTES; k++) begin
            if (8'(k) < sbytes) wr_data[k*8 +: 8] = src_b_lo[k*8 +: 8];
        end
    end

endmodule

// File: rtl/tlu_bank.sv
module tlu_bank #(
    parameter int NUM_TABLES  = 8,
    parameter int TABLE_DEPTH = 256,
    parameter int ENTRY_BYTES = 4
) (
    input  logic                                   clk,
    input  logic [NUM_TABLES-1:0]                  rd_en,
    input  logic [NUM_TABLES-1:0][7:0]             rd_idx,
    input  logic [NUM_TABLES-1:0]                  wr_en,
    input  logic [7:0]                             wr_idx,
    input  logic [ENTRY_BYTES*8-1:0]               wr_data,
    output logic [NUM_TABLES-1:0][ENTRY_BYTES*8-1:0] rd_q
);

    localparam int EW    = ENTRY_BYTES * 8;
    localparam int IDX_W = $clog2(TABLE_DEPTH);

    // each table: one read port, one write port
    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tab
        logic [EW-1:0] mem [TABLE_DEPTH];
        logic [EW-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_en[t]) mem[wr_idx[IDX_W-1:0]] <= wr_data;
            if (rd_en[t]) q <= mem[rd_idx[t][IDX_W-1:0]];
        end

        assign rd_q[t] = q;
    end

endmodule

// File: rtl/tlu_pack.sv
module tlu_pack #(
    parameter int WORD_BYTES  = 8,
    parameter int ENTRY_BYTES = 4,
    parameter int NUM_TABLES  = 8
) (
    input  logic [NUM_TABLES-1:0][ENTRY_BYTES*8-1:0] rd_q,
    input  logic [7:0]                               cnt,
    input  logic [2:0]                               sz,
    output logic [WORD_BYTES*8-1:0]                  word
);

    localparam logic [7:0] WB8 = 8'(WORD_BYTES);

    logic [7:0] sbytes;
    assign sbytes = 8'd1 << sz;

    always_comb begin
        word = '0;
        for (int j = 0; j < NUM_TABLES; j++) begin
            for (int k = 0; k < ENTRY_BYTES; k++) begin
                if ((8'(j) < cnt) && (8'(k) < sbytes)
                    && (((8'(j) << sz) + 8'(k)) < WB8)) begin
                    word[{(8'(j) << sz) + 8'(k), 3'b000} +: 8] = rd_q[j][k*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/tbl_lookup_unit.sv
module tbl_lookup_unit
    import tlu_pkg::*;
#(
    parameter int WORD_BYTES  = 8,
    parameter int ENTRY_BYTES = 4,
    parameter int NUM_TABLES  = 8,
    parameter int TABLE_DEPTH = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_valid,
    input  logic                    issue_op,
    input  logic [2:0]              issue_fa,
    input  logic [2:0]              issue_size,
    input  logic [3:0]              issue_off,
    input  logic [WORD_BYTES*8-1:0] src_a,
    input  logic [WORD_BYTES*8-1:0] src_b,
    output logic                    done,
    output logic                    err,
    output logic [WORD_BYTES*8-1:0] result
);

    localparam int WW = WORD_BYTES * 8;
    localparam int EW = ENTRY_BYTES * 8;

    logic                         legal;
    logic [7:0]                   cnt;
    logic [NUM_TABLES-1:0]        rd_en, wr_en;
    logic [NUM_TABLES-1:0][7:0]   rd_idx;
    logic [7:0]                   wr_idx;
    logic [EW-1:0]                wr_data;
    logic [NUM_TABLES-1:0][EW-1:0] rd_q;
    logic [WW-1:0]                packed_word;

    res_state_e state, nxt;
    logic [7:0] cnt_q;
    logic [2:0] sz_q;

    tlu_decode #(
        .WORD_BYTES (WORD_BYTES),
        .ENTRY_BYTES(ENTRY_BYTES),
        .NUM_TABLES (NUM_TABLES)
    ) u_dec (
        .valid   (issue_valid),
        .op      (issue_op),
        .fa      (issue_fa),
        .sz      (issue_size),
        .off     (issue_off),
        .src_a   (src_a),
        .src_b_lo(src_b[EW-1:0]),
        .legal   (legal),
        .cnt     (cnt),
        .rd_en   (rd_en),
        .rd_idx  (rd_idx),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    tlu_bank #(
        .NUM_TABLES (NUM_TABLES),
        .TABLE_DEPTH(TABLE_DEPTH),
        .ENTRY_BYTES(ENTRY_BYTES)
    ) u_bank (
        .clk    (clk),
        .rd_en  (rd_en),
        .rd_idx (rd_idx),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_q   (rd_q)
    );

    tlu_pack #(
        .WORD_BYTES (WORD_BYTES),
        .ENTRY_BYTES(ENTRY_BYTES),
        .NUM_TABLES (NUM_TABLES)
    ) u_pack (
        .rd_q(rd_q),
        .cnt (cnt_q),
        .sz  (sz_q),
        .word(packed_word)
    );

    // next state of the result tracker
    always_comb begin
        if (!issue_valid)            nxt = S_IDLE;
        else if (!legal)             nxt = S_FAULT;
        else if (issue_op == OP_WRITE) nxt = S_WRITE;
        else                         nxt = S_LOOKUP;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // lookup shape held for the packer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= 8'd1;
            sz_q  <= 3'd0;
        end else if (issue_valid && legal && (issue_op == OP_LOOKUP)) begin
            cnt_q <= cnt;
            sz_q  <= issue_size;
        end
    end

    // outputs
    always_comb begin
        done   = 1'b0;
        err    = 1'b0;
        result = '0;
        unique case (state)
            S_IDLE:   ;
            S_LOOKUP: begin
                done   = 1'b1;
                result = packed_word;
            end
            S_WRITE:  done = 1'b1;
            S_FAULT:  begin
                done = 1'b1;
                err  = 1'b1;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/tbl_lookup_unit_chk.sv
module tbl_lookup_unit_chk
    import tlu_pkg::*;
#(
    parameter int WORD_BYTES = 8,
    parameter int NUM_TABLES = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    issue_valid,
    input logic                    issue_op,
    input logic [2:0]              issue_size,
    input logic                    done,
    input logic                    err,
    input logic [WORD_BYTES*8-1:0] result,
    input logic [NUM_TABLES-1:0]   wr_en
);

    p_done_after_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> done);

    p_quiet_after_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!done && !err && result == '0));

    p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && result == '0));

    p_reserved_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_size > SIZE_CODE_MAX) |=> err);

    p_one_table_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    p_write_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_op == OP_WRITE) |=> (result == '0));

endmodule

bind tbl_lookup_unit tbl_lookup_unit_chk #(
    .WORD_BYTES(WORD_BYTES),
    .NUM_TABLES(NUM_TABLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_valid(issue_valid),
    .issue_op   (issue_op),
    .issue_size (issue_size),
    .done       (done),
    .err        (err),
    .result     (result),
    .wr_en      (wr_en)
);

// File: tb/tbl_lookup_unit_tb_top.sv
`timescale 1ns/1ps
module tbl_lookup_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_op = 1'b0;
    logic [2:0]  issue_fa = '0;
    logic [2:0]  issue_size = '0;
    logic [3:0]  issue_off = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        done, err;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] ref_tab [8][256];

    always #2.5 clk = ~clk;

    tbl_lookup_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_fa(issue_fa), .issue_size(issue_size), .issue_off(issue_off),
        .src_a(src_a), .src_b(src_b), .done(done), .err(err), .result(result)
    );

    typedef struct packed {
        logic [2:0]  fa;
        logic [2:0]  sz;
        logic [3:0]  off;
        logic [63:0] sa;
        logic        xerr;
    } lvec_t;

    localparam int NV = 12;
    localparam lvec_t VECS [NV] = '{
        '{3'd7, 3'd0, 4'd0, 64'h0123_4567_89AB_CDEF, 1'b0}, // R1 R2 eight 1-byte
        '{3'd1, 3'd2, 4'd0, 64'h0000_0000_0000_7F80, 1'b0}, // R4 two 4-byte
        '{3'd3, 3'd1, 4'd2, 64'h00FE_DC11_2233_0000, 1'b0}, // R1 R4 four 2-byte
        '{3'd0, 3'd3, 4'd7, 64'hA500_0000_0000_0000, 1'b0}, // R3 8-byte zero-ext
        '{3'd0, 3'd4, 4'd0, 64'h0000_0000_0000_0010, 1'b1}, // R7 16 bytes
        '{3'd2, 3'd2, 4'd0, 64'h0000_0000_0001_0203, 1'b1}, // R7 3x4
        '{3'd3, 3'd0, 4'd5, 64'h1122_3344_5566_7788, 1'b1}, // R8 past byte 7
        '{3'd0, 3'd5, 4'd0, 64'h0000_0000_0000_0001, 1'b1}, // R6 reserved
        '{3'd0, 3'd7, 4'd0, 64'h0000_0000_0000_0001, 1'b1}, // R6 reserved
        '{3'd3, 3'd0, 4'd4, 64'hC3D2_E1F0_0000_0000, 1'b0}, // R8 exact fit
        '{3'd1, 3'd2, 4'd6, 64'h3A5B_0000_0000_0000, 1'b0}, // R1 R4 high offset
        '{3'd0, 3'd0, 4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1} // R8 offset 15
    };

    function automatic logic [31:0] pat(int t, int i);
        return {8'(i) + 8'(t), 8'(t) ^ 8'hC3, ~8'(i), 8'(i) ^ 8'(t * 37)};
    endfunction

    function automatic bit lk_legal(logic [2:0] fa, logic [2:0] sz, logic [3:0] off);
        int c = int'(fa) + 1;
        if (sz > 3'd4) return 1'b0;
        if ((c << sz) > 8) return 1'b0;
        if (int'(off) + c - 1 > 7) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [63:0] lk_model(logic [2:0] fa, logic [2:0] sz,
                                             logic [3:0] off, logic [63:0] sa);
        logic [63:0] r = '0;
        int c = int'(fa) + 1;
        int d = 1 << sz;
        for (int j = 0; j < c; j++) begin
            logic [7:0]  idx = sa[(int'(off) + j) * 8 +: 8];
            logic [31:0] e   = ref_tab[j][idx];
            for (int k = 0; k < d; k++) begin
                if (k < 4) r[(j * d + k) * 8 +: 8] = e[k * 8 +: 8];
            end
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        g_done, g_err;
    logic [63:0] g_res;

    task automatic do_op(logic op, logic [2:0] fa, logic [2:0] sz, logic [3:0] off,
                         logic [63:0] sa, logic [63:0] sb);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op; issue_fa = fa;
        issue_size = sz; issue_off = off; src_a = sa; src_b = sb;
        @(negedge clk);
        g_done = done; g_err = err; g_res = result;
        issue_valid = 1'b0;
    endtask

    task automatic report;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R10 actual=%h expected=%h", 64'h0, 64'h1);
            report();
            $finish;
        end
    end

    initial begin
        logic [63:0] want;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check(!done && !err && result == '0, "R10 reset", {62'b0, done, err}, 64'h0);
        rst_n = 1'b1;

        // fill all tables with 4-byte writes (R5, R11)
        begin
            int wfail = 0;
            for (int t = 0; t < 8; t++) begin
                for (int i = 0; i < 256; i++) begin
                    do_op(1'b1, 3'(t), 3'd2, 4'd0, 64'(i), {32'hDEAD_BEEF, pat(t, i)});
                    ref_tab[t][i] = pat(t, i);
                    if (!g_done || g_err || g_res != '0) wfail++;
                end
            end
            check(wfail == 0, "R11 write ack", 64'(wfail), 64'h0);
        end

        // vector table walk
        for (int v = 0; v < NV; v++) begin
            lvec_t vc = VECS[v];
            do_op(1'b0, vc.fa, vc.sz, vc.off, vc.sa, 64'h0);
            want = vc.xerr ? 64'h0 : lk_model(vc.fa, vc.sz, vc.off, vc.sa);
            check(lk_legal(vc.fa, vc.sz, vc.off) == !vc.xerr, "R7 bench legality",
                  64'(v), 64'(v));
            check(g_done && g_err == vc.xerr, "R1 R6 R7 R8 flag", {63'b0, g_err},
                  {63'b0, vc.xerr});
            check(g_res == want, "R1 R2 R3 R4 data", g_res, want);
        end

        // R3: explicit zero-extension of an 8-byte read of T0[0xA5]
        do_op(1'b0, 3'd0, 3'd3, 4'd7, 64'hA500_0000_0000_0000, 64'h0);
        check(g_res == {32'h0, pat(0, 8'hA5)}, "R3 zero ext", g_res, {32'h0, pat(0, 8'hA5)});

        // R10: idle cycle after an issue
        @(negedge clk);
        check(!done && !err && result == '0, "R10 idle", result, 64'h0);

        // R5: 1-byte write into T1[0x40] via offset 3, upper entry bytes zeroed
        do_op(1'b1, 3'd1, 3'd0, 4'd3, 64'h0000_0000_4000_0000, 64'hFFFF_FFFF_FFFF_FF9E);
        check(g_done && !g_err && g_res == '0, "R11 write result", g_res, 64'h0);
        do_op(1'b0, 3'd1, 3'd2, 4'd0, 64'h0000_0000_0000_4000, 64'h0);
        check(g_res[63:32] == 32'h0000_009E, "R5 write data", {32'h0, g_res[63:32]}, 64'h9E);
        check(g_res[31:0] == pat(0, 0), "R5 other table intact", {32'h0, g_res[31:0]},
              {32'h0, pat(0, 0)});

        // R9: 8-byte write into a 4-byte entry is refused
        do_op(1'b1, 3'd1, 3'd3, 4'd3, 64'h0000_0000_4000_0000, 64'h1111_1111_1111_1111);
        check(g_err && g_res == '0, "R9 wide write err", {63'b0, g_err}, 64'h1);
        // R6: reserved size on a write
        do_op(1'b1, 3'd1, 3'd6, 4'd3, 64'h0000_0000_4000_0000, 64'h2222_2222_2222_2222);
        check(g_err && g_res == '0, "R6 reserved write err", {63'b0, g_err}, 64'h1);
        // R8: write offset beyond the word
        do_op(1'b1, 3'd1, 3'd2, 4'd9, 64'h4040_4040_4040_4040, 64'h3333_3333_3333_3333);
        check(g_err && g_res == '0, "R8 write offset err", {63'b0, g_err}, 64'h1);
        do_op(1'b0, 3'd1, 3'd2, 4'd0, 64'h0000_0000_0000_4000, 64'h0);
        check(g_res[63:32] == 32'h0000_009E, "R6 R8 R9 entry unchanged",
              {32'h0, g_res[63:32]}, 64'h9E);

        // R2: count code 0 returns exactly one lookup
        do_op(1'b0, 3'd0, 3'd2, 4'd0, 64'hFFFF_FFFF_FFFF_FF07, 64'h0);
        check(g_res == {32'h0, pat(0, 7)}, "R2 single lookup", g_res, {32'h0, pat(0, 7)});

        finished = 1'b1;
        report();
        $finish;
    end

endmodule